// File: doc/BRIEF.md
# Classic-to-Pipelined Half-Width Bus Bridge

This block lets a 32-bit Wishbone master that follows the classic handshake (strobe held until acknowledge) reach a 64-bit Wishbone bus that uses the pipelined handshake (strobe accepted when stall is low, acknowledge later). The narrow side addresses 32-bit words and the wide side addresses 64-bit doublewords. The bridge therefore drops the lowest word-address bit to form the doubleword address, and uses that bit to choose the 32-bit half.

On a write, the byte lanes are placed in the chosen half of the wide select and the write data is copied into both halves. On a read, the chosen half of the returned doubleword goes back to the narrow master. The request and the response each pass through a register, so a transaction takes two more cycles than a direct connection. Only one transaction is in flight at a time.

Top module: `wb_half_bridge`

## Requirements
- R1: After reset, `n_ack`, `w_cyc` and `w_stb` are low until a narrow request is presented.
- R2: The wide address issued equals the narrow word address shifted right by one bit.
- R3: On a write, narrow address bit 0 = 0 places `n_sel` in `w_sel[3:0]` with `w_sel[7:4]` = 0. Bit 0 = 1 places it in `w_sel[7:4]` with `w_sel[3:0]` = 0. `w_dat_w` carries the write word in both halves.
- R4: On a read, `n_dat_r` is `w_dat_r[63:32]` when narrow address bit 0 = 1, or `w_dat_r[31:0]` when it is 0. The value is taken in the cycle that `w_ack` is high.
- R5: Each narrow request produces exactly one accepted wide beat. `w_stb` stays high with a stable address while `w_stall` is high, and drops after the first cycle in which `w_stall` is low.
- R6: A request is first seen at clock edge 1. The slave stalls for s edges and asserts `w_ack` d cycles after it accepts the beat. Under these conditions `n_ack` is high in the cycle after edge 3+s+d, which is two cycles later than a direct connection.
- R7: `n_ack` is a single-cycle pulse and is not gated by `n_cyc`. If the master drops `n_cyc` and `n_stb` after the request is taken, the bridge still finishes the wide transaction and pulses `n_ack` on schedule.
- R8: A new narrow request is not accepted before the previous one is acknowledged. A request whose strobe is still high in the acknowledge cycle does not start a second wide beat.
- R9: `w_cyc` stays high from the issue of the beat until `w_ack` is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_cyc | input | 1 | Narrow cycle |
| n_stb | input | 1 | Narrow strobe (classic) |
| n_we | input | 1 | Narrow write enable |
| n_adr | input | NAW | Narrow word address |
| n_dat_w | input | NDW | Narrow write data |
| n_sel | input | NDW/8 | Narrow byte select |
| n_dat_r | output | NDW | Narrow read data |
| n_ack | output | 1 | Narrow acknowledge |
| w_cyc | output | 1 | Wide cycle |
| w_stb | output | 1 | Wide strobe (pipelined) |
| w_we | output | 1 | Wide write enable |
| w_adr | output | NAW-1 | Wide doubleword address |
| w_dat_w | output | 2*NDW | Wide write data |
| w_sel | output | NDW/4 | Wide byte select |
| w_dat_r | input | 2*NDW | Wide read data |
| w_ack | input | 1 | Wide acknowledge |
| w_stall | input | 1 | Wide stall |

## Verification
Each fault in the sequencer shows up at the ports within a few cycles of the transaction that exposes it.

- A stale half-select bit puts the byte lanes in the wrong nibble, or returns the other word, on the very next access with the opposite address parity.
- A strobe dropped or held wrongly around stall changes the count of accepted beats in that same transaction.
- A wrong state transition moves the acknowledge away from edge 3+s+d, or adds a second pulse one cycle later.

The bench therefore varies stall and acknowledge delay, address parity and early strobe removal. It checks the beat count, the latency and the data for every transaction.

// File: rtl/wb_half_bridge.sv
module wb_half_bridge #(
  parameter int NAW = 30,
  parameter int NDW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               n_cyc,
  input  logic               n_stb,
  input  logic               n_we,
  input  logic [NAW-1:0]     n_adr,
  input  logic [NDW-1:0]     n_dat_w,
  input  logic [NDW/8-1:0]   n_sel,
  output logic [NDW-1:0]     n_dat_r,
  output logic               n_ack,
  output logic               w_cyc,
  output logic               w_stb,
  output logic               w_we,
  output logic [NAW-2:0]     w_adr,
  output logic [2*NDW-1:0]   w_dat_w,
  output logic [NDW/4-1:0]   w_sel,
  input  logic [2*NDW-1:0]   w_dat_r,
  input  logic               w_ack,
  input  logic               w_stall
);
  localparam int NSW = NDW / 8;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_t;

  st_t              st;
  logic             hi_q;
  logic             we_q;
  logic [NAW-2:0]   adr_q;
  logic [NDW-1:0]   dat_q;
  logic [NSW-1:0]   sel_q;
  logic [NDW-1:0]   rd_q;
  logic [NDW-1:0]   rd_half;

  assign rd_half = hi_q ? w_dat_r[NDW +: NDW] : w_dat_r[0 +: NDW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE:  if (n_cyc && n_stb) st <= S_ISSUE;
        S_ISSUE: if (!w_stall) st <= w_ack ? S_RESP : S_WAIT;
        S_WAIT:  if (w_ack) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && n_cyc && n_stb) begin
      hi_q  <= n_adr[0];
      adr_q <= n_adr[NAW-1:1];
      we_q  <= n_we;
      dat_q <= n_dat_w;
      sel_q <= n_sel;
    end
    if ((st == S_ISSUE && !w_stall && w_ack) || (st == S_WAIT && w_ack))
      rd_q <= rd_half;
  end

  assign w_cyc   = (st == S_ISSUE) || (st == S_WAIT);
  assign w_stb   = (st == S_ISSUE);
  assign w_we    = we_q;
  assign w_adr   = adr_q;
  assign w_dat_w = {dat_q, dat_q};
  assign w_sel   = hi_q ? {sel_q, {NSW{1'b0}}} : {{NSW{1'b0}}, sel_q};
  assign n_ack   = (st == S_RESP);
  assign n_dat_r = rd_q;

  // R9
  stb_in_cyc_chk: assert property (@(posedge clk) disable iff (rst)
    w_stb |-> w_cyc);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (w_stb && w_stall) |=> (w_stb && $stable(w_adr)));

  // R5
  one_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (w_stb && !w_stall) |=> !w_stb);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    n_ack |=> !n_ack);

  // R4
  ack_follows_wide_chk: assert property (@(posedge clk) disable iff (rst)
    n_ack |-> $past(w_ack));

  // R8
  no_issue_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    n_ack |=> !w_cyc);
endmodule

// File: tb/wb_half_bridge_tb.sv
`timescale 1ns/1ps
module wb_half_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        n_cyc = 0, n_stb = 0, n_we = 0;
  logic [29:0] n_adr = '0;
  logic [31:0] n_dat_w = '0;
  logic [3:0]  n_sel = '0;
  logic [31:0] n_dat_r;
  logic        n_ack;
  logic        w_cyc, w_stb, w_we;
  logic [28:0] w_adr;
  logic [63:0] w_dat_w;
  logic [7:0]  w_sel;
  logic [63:0] w_dat_r;
  logic        w_ack;
  logic        w_stall;

  always #4 clk = ~clk;

  wb_half_bridge dut_i (
    .clk(clk), .rst(rst),
    .n_cyc(n_cyc), .n_stb(n_stb), .n_we(n_we), .n_adr(n_adr),
    .n_dat_w(n_dat_w), .n_sel(n_sel), .n_dat_r(n_dat_r), .n_ack(n_ack),
    .w_cyc(w_cyc), .w_stb(w_stb), .w_we(w_we), .w_adr(w_adr),
    .w_dat_w(w_dat_w), .w_sel(w_sel), .w_dat_r(w_dat_r),
    .w_ack(w_ack), .w_stall(w_stall)
  );

  // Slave model
  int          stall_cfg = 0;
  int          dly_cfg = 0;
  int          stall_seen = 0;
  int          cnt = 0;
  int          beats = 0;
  logic [63:0] mem [16];
  logic [63:0] hold;
  logic [28:0] last_adr;
  logic [7:0]  last_sel;
  logic [63:0] last_dat;
  logic        last_we;

  function automatic logic [63:0] init_dw(input int i);
    return {16'hA5A5, 16'(i), 16'h5A5A, 16'(i + 100)};
  endfunction

  logic [63:0] ref_mem [16];
  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = init_dw(i);
      ref_mem[i] = init_dw(i);
    end
  end

  assign w_stall = w_stb && (stall_seen < stall_cfg);

  always @(posedge clk) begin
    w_ack   <= 1'b0;
    w_dat_r <= 64'hDEAD_BEEF_0BAD_F00D;
    if (rst) begin
      cnt <= 0;
      stall_seen <= 0;
    end else if (w_cyc && w_stb && !w_stall) begin
      stall_seen <= 0;
      beats    <= beats + 1;
      last_adr <= w_adr;
      last_sel <= w_sel;
      last_dat <= w_dat_w;
      last_we  <= w_we;
      if (w_we)
        for (int b = 0; b < 8; b++)
          if (w_sel[b]) mem[w_adr[3:0]][8*b +: 8] <= w_dat_w[8*b +: 8];
      if (dly_cfg == 0) begin
        w_ack   <= 1'b1;
        w_dat_r <= mem[w_adr[3:0]];
      end else begin
        hold <= mem[w_adr[3:0]];
        cnt  <= dly_cfg;
      end
    end else begin
      if (w_stb && w_stall) stall_seen <= stall_seen + 1;
      if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          w_ack   <= 1'b1;
          w_dat_r <= hold;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic we, input logic [29:0] a, input logic [3:0] sel,
                      input logic [31:0] d, input int s, input int dl, input bit drop,
                      output logic [31:0] rd);
    int lat = 0;
    int b0;
    bit cyc_ok = 1;
    @(negedge clk);
    stall_cfg = s;
    dly_cfg = dl;
    b0 = beats;
    n_cyc = 1; n_stb = 1; n_we = we; n_adr = a; n_sel = sel; n_dat_w = d;
    forever begin
      @(negedge clk);
      lat++;
      if (drop && lat == 1) begin n_cyc = 0; n_stb = 0; end
      if (n_ack || lat > 60) break;
      if (lat >= 2 && !w_ack && !w_cyc && cnt != 0) cyc_ok = 0;
    end
    rd = n_dat_r;
    chk("R6 latency", 64'(lat), 64'(3 + s + dl));
    chk("R9 cyc held", 64'(cyc_ok), 64'd1);
    n_cyc = 0; n_stb = 0;
    @(negedge clk);
    chk("R7 ack single pulse", 64'(n_ack), 64'd0);
    chk("R5 R8 one beat", 64'(beats - b0), 64'd1);
    chk("R2 wide address", 64'(last_adr), 64'(a >> 1));
    if (we) begin
      chk("R3 select lanes", 64'(last_sel), a[0] ? 64'({sel, 4'h0}) : 64'({4'h0, sel}));
      chk("R3 data copy", last_dat, {d, d});
      for (int b = 0; b < 4; b++)
        if (sel[b]) ref_mem[a[4:1]][32*a[0] + 8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic t_write(input logic [29:0] a, input logic [3:0] sel, input logic [31:0] d,
                         input int s, input int dl);
    logic [31:0] rd;
    xact(1'b1, a, sel, d, s, dl, 1'b0, rd);
  endtask

  task automatic t_read(input logic [29:0] a, input int s, input int dl, input bit drop);
    logic [31:0] rd;
    logic [63:0] e;
    xact(1'b0, a, 4'hF, 32'h0, s, dl, drop, rd);
    e = ref_mem[a[4:1]];
    chk("R4 read half", 64'(rd), a[0] ? 64'(e[63:32]) : 64'(e[31:0]));
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 n_ack reset", 64'(n_ack), 0);
    chk("R1 w_cyc reset", 64'(w_cyc), 0);
    chk("R1 w_stb reset", 64'(w_stb), 0);
    t_write(30'h6, 4'b1011, 32'h1122_3344, 0, 0);
    t_write(30'h7, 4'hF, 32'hCAFE_F00D, 2, 1);
    t_write(30'h9, 4'b0100, 32'h00EE_0000, 1, 3);
    t_read(30'h7, 0, 0, 0);
    t_read(30'h6, 3, 4, 0);
    t_read(30'h9, 0, 2, 0);
    t_read(30'h8, 1, 0, 1);
    t_read(30'h1F, 4, 1, 1);
    t_write(30'h1E, 4'b0001, 32'h0000_00AB, 0, 0);
    t_read(30'h1E, 2, 2, 0);
    t_read(30'h1F, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule